// File: doc/BRIEF.md
# Nibble-Accessed Reloadable Timer Bank

This block holds four 8-bit down-counters: a prescaler and three timers. Each has a reload register, and the third timer has a second one. A processor with a 4-bit datapath reaches them through two nibble buses. The high-nibble bus carries bits 7..4 and the low-nibble bus carries bits 3..0. The processor drives a one-hot transfer command to do one of these:

- read a counter;
- write a counter together with its reload register;
- write only a reload register;
- copy the third timer's low reload value into its counter.

Each counter has a tick input. On a tick the counter decrements. On a tick while it holds zero, it reloads instead of decrementing, and it raises its underflow line in that same cycle. The underflow line is meant to set an interrupt request flag elsewhere.

The third timer alternates between its two reload values, so it can produce two-phase periods. Its phase is visible on a port. Clock source selection and instruction decoding belong to the surrounding logic.

Top module: `nibtmr_top`

## Requirements
- R1: A synchronous active-high reset clears all four counters, all reload registers and the timer 3 phase to zero.
- R2: Read commands use these `cmd` bits: bit 0 reads the prescaler, bit 2 reads timer 1, bit 5 reads timer 2 and bit 7 reads timer 3. A read places bits 7..4 of the selected counter on `hi_out` and bits 3..0 on `lo_out` in the same cycle. When no valid read is present, both outputs are 0.
- R3: Write commands use these `cmd` bits: bit 1 for the prescaler, bit 3 for timer 1, bit 6 for timer 2 and bit 8 for timer 3. A write loads {`hi_in`,`lo_in`} into both the counter and its low reload register at the next clock edge. A timer 3 write also returns its phase to 0.
- R4: Bit 4 of `cmd` writes {`hi_in`,`lo_in`} into the timer 1 reload register only. The timer 1 counter is unchanged by it.
- R5: Bit 9 of `cmd` writes {`hi_in`,`lo_in`} into the timer 3 high reload register only. The timer 3 counter is unchanged by it.
- R6: Bit 10 of `cmd` copies the timer 3 low reload register into the timer 3 counter and sets the phase to 0.
- R7: On a cycle with its `tick` bit high, a counter holding a non-zero value decrements by one. A counter holding zero reloads from its low reload register instead. `uf` bit i is high exactly in the cycles where `tick` bit i is high and counter i is zero. Bit order is prescaler, timer 1, timer 2, timer 3.
- R8: Timer 3 alternates its reload source on underflow. In phase 0 it reloads from the high reload register and enters phase 1. In phase 1 it reloads from the low register and returns to phase 0. `phase` bit 3 shows the timer 3 phase, and bits 2..0 stay 0.
- R9: A counter write or a timer 3 copy command takes priority over a tick or an underflow reload in the same cycle.
- R10: If more than one `cmd` bit is high in a cycle, no register is written and both read outputs are 0. Ticks still act.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd | input | 11 | One-hot transfer command |
| lo_in | input | 4 | Low data nibble from the processor |
| hi_in | input | 4 | High data nibble from the processor |
| tick | input | 4 | Per-counter count enable pulse |
| lo_out | output | 4 | Low nibble of the counter being read |
| hi_out | output | 4 | High nibble of the counter being read |
| uf | output | 4 | Per-counter underflow pulse |
| phase | output | 4 | Reload phase per counter; only bit 3 can be 1 |

## Verification
A corrupted counter or reload register reaches the ports in two ways. It shows at the read outputs on the next read of that counter. It also changes the cycle in which `uf` pulses, because the reload value sets the length of every later period. A wrong phase in timer 3 appears on `phase` within one cycle. It then swaps the long and short periods at the following underflow. The reference model is compared on every clock, so a divergence is caught in the first cycle it reaches any output, not at the end of a scenario.

// File: rtl/nibtmr_pkg.sv
package nibtmr_pkg;
    localparam int NIB_W = 4;
    localparam int CNT_W = 2 * NIB_W;
    localparam int N_CNT = 4;
    localparam int CMD_W = 11;
    localparam int IDX_W = $clog2(N_CNT);

    // counter slots
    localparam int IDX_PS = 0;
    localparam int IDX_T1 = 1;
    localparam int IDX_T2 = 2;
    localparam int IDX_T3 = 3;

    // command bit positions
    localparam int C_RD_PS  = 0;
    localparam int C_WR_PS  = 1;
    localparam int C_RD_T1  = 2;
    localparam int C_WR_T1  = 3;
    localparam int C_WR_R1  = 4;
    localparam int C_RD_T2  = 5;
    localparam int C_WR_T2  = 6;
    localparam int C_RD_T3  = 7;
    localparam int C_WR_T3  = 8;
    localparam int C_WR_R3H = 9;
    localparam int C_LD_T3  = 10;

    typedef logic [CNT_W-1:0] cnt_t;
    typedef logic [NIB_W-1:0] nib_t;

    typedef struct packed {
        logic [N_CNT-1:0] wr_cnt;
        logic [N_CNT-1:0] wr_rl;
        logic [N_CNT-1:0] wr_rh;
        logic [N_CNT-1:0] ld_low;
        logic             rd_en;
        logic [IDX_W-1:0] rd_idx;
    } strobe_t;

    function automatic cnt_t join_nib(input nib_t hi, input nib_t lo);
        return {hi, lo};
    endfunction
endpackage

// File: rtl/nibtmr_decode.sv
module nibtmr_decode
    import nibtmr_pkg::*;
(
    input  logic [CMD_W-1:0] cmd,
    output strobe_t          stb
);
    always_comb begin
        stb = '0;
        if ($onehot(cmd)) begin
            stb.wr_cnt[IDX_PS] = cmd[C_WR_PS];
            stb.wr_cnt[IDX_T1] = cmd[C_WR_T1];
            stb.wr_cnt[IDX_T2] = cmd[C_WR_T2];
            stb.wr_cnt[IDX_T3] = cmd[C_WR_T3];
            stb.wr_rl[IDX_T1]  = cmd[C_WR_R1];
            stb.wr_rh[IDX_T3]  = cmd[C_WR_R3H];
            stb.ld_low[IDX_T3] = cmd[C_LD_T3];
            stb.rd_en = cmd[C_RD_PS] | cmd[C_RD_T1] | cmd[C_RD_T2] | cmd[C_RD_T3];
            if (cmd[C_RD_T1])      stb.rd_idx = IDX_W'(IDX_T1);
            else if (cmd[C_RD_T2]) stb.rd_idx = IDX_W'(IDX_T2);
            else if (cmd[C_RD_T3]) stb.rd_idx = IDX_W'(IDX_T3);
            else                   stb.rd_idx = IDX_W'(IDX_PS);
        end
    end
endmodule

// File: rtl/nibtmr_counter.sv
module nibtmr_counter
    import nibtmr_pkg::*;
#(
    parameter bit DUAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic wr_cnt,
    input  logic wr_rl,
    input  logic wr_rh,
    input  logic ld_low,
    input  cnt_t din,
    output cnt_t cnt_q,
    output logic uf,
    output logic phase_q
);
    cnt_t rl_q;
    cnt_t rh_q;
    logic zero;

    assign zero = (cnt_q == '0);
    assign uf   = tick && zero;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            rl_q    <= '0;
            rh_q    <= '0;
            phase_q <= 1'b0;
        end else begin
            if (wr_cnt || wr_rl) rl_q <= din;
            if (wr_rh)           rh_q <= din;
            if (wr_cnt) begin
                cnt_q   <= din;
                phase_q <= 1'b0;
            end else if (ld_low) begin
                cnt_q   <= rl_q;
                phase_q <= 1'b0;
            end else if (tick) begin
                if (!zero) begin
                    cnt_q <= cnt_q - 1'b1;
                end else if (DUAL && !phase_q) begin
                    cnt_q   <= rh_q;
                    phase_q <= 1'b1;
                end else begin
                    cnt_q   <= rl_q;
                    phase_q <= 1'b0;
                end
            end
        end
    end

    // R3
    wr_load_chk: assert property (@(posedge clk) disable iff (rst)
        wr_cnt |=> (cnt_q == $past(din)));

    // R7
    dec_step_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && !zero && !wr_cnt && !ld_low) |=> (cnt_q == $past(cnt_q) - 1'b1));

    // R6
    ld_low_chk: assert property (@(posedge clk) disable iff (rst)
        (ld_low && !wr_cnt) |=> (cnt_q == $past(rl_q)));

    // R4
    rl_only_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_rl && !wr_cnt && !ld_low && !tick) |=> $stable(cnt_q));

    // R8
    phase_flip_chk: assert property (@(posedge clk) disable iff (rst)
        (DUAL && uf && !phase_q && !wr_cnt && !ld_low) |=> phase_q);
endmodule

// File: rtl/nibtmr_top.sv
module nibtmr_top
    import nibtmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [CMD_W-1:0] cmd,
    input  logic [NIB_W-1:0] lo_in,
    input  logic [NIB_W-1:0] hi_in,
    input  logic [N_CNT-1:0] tick,
    output logic [NIB_W-1:0] lo_out,
    output logic [NIB_W-1:0] hi_out,
    output logic [N_CNT-1:0] uf,
    output logic [N_CNT-1:0] phase
);
    strobe_t stb;
    cnt_t    din;
    cnt_t    cnt_q [N_CNT];
    cnt_t    rd_val;

    assign din = join_nib(hi_in, lo_in);

    nibtmr_decode i_decode (
        .cmd (cmd),
        .stb (stb)
    );

    for (genvar i = 0; i < N_CNT; i++) begin : g_cnt
        nibtmr_counter #(.DUAL(i == IDX_T3)) i_counter (
            .clk     (clk),
            .rst     (rst),
            .tick    (tick[i]),
            .wr_cnt  (stb.wr_cnt[i]),
            .wr_rl   (stb.wr_rl[i]),
            .wr_rh   (stb.wr_rh[i]),
            .ld_low  (stb.ld_low[i]),
            .din     (din),
            .cnt_q   (cnt_q[i]),
            .uf      (uf[i]),
            .phase_q (phase[i])
        );
    end

    assign rd_val = stb.rd_en ? cnt_q[stb.rd_idx] : '0;
    assign hi_out = rd_val[CNT_W-1:NIB_W];
    assign lo_out = rd_val[NIB_W-1:0];

    // R10
    one_action_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({stb.wr_cnt, stb.wr_rl, stb.wr_rh, stb.ld_low, stb.rd_en}));

    // R10
    multi_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        ($countones(cmd) > 1) |-> ({hi_out, lo_out} == '0));

    // R8
    phase_low_chk: assert property (@(posedge clk) disable iff (rst)
        (phase[IDX_T3-1:0] == '0));
endmodule

// File: tb/test_nibtmr_top.sv
`timescale 1ns/1ps
module test_nibtmr_top;
    logic        clk = 1'b0;
    logic        rst;
    logic [10:0] cmd;
    logic [3:0]  lo_in, hi_in, tick;
    logic [3:0]  lo_out, hi_out, uf, phase;

    int compared = 0;
    int mismatched = 0;
    bit done = 0;

    int m_cnt [4];
    int m_rl  [4];
    int m_rh;
    int m_ph;

    always #2 clk = ~clk;

    nibtmr_top i_nibtmr_top (
        .clk(clk), .rst(rst), .cmd(cmd), .lo_in(lo_in), .hi_in(hi_in),
        .tick(tick), .lo_out(lo_out), .hi_out(hi_out), .uf(uf), .phase(phase)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic step(input bit r, input logic [10:0] c, input logic [7:0] d,
                        input logic [3:0] tk, input string req);
        int rdv, wc, n_cnt [4], n_rl [4], n_rh, n_ph;
        bit one;
        @(negedge clk);
        rst = r; cmd = c; hi_in = d[7:4]; lo_in = d[3:0]; tick = tk;
        #1;
        one = ($countones(c) == 1);
        rdv = 0;
        if (one && c[0]) rdv = m_cnt[0];
        if (one && c[2]) rdv = m_cnt[1];
        if (one && c[5]) rdv = m_cnt[2];
        if (one && c[7]) rdv = m_cnt[3];
        check(req, "hi_out", hi_out, rdv / 16);
        check(req, "lo_out", lo_out, rdv % 16);
        for (int i = 0; i < 4; i++)
            check(req, $sformatf("uf[%0d]", i), uf[i], (tk[i] && m_cnt[i] == 0) ? 1 : 0);
        check(req, "phase", phase, m_ph * 8);
        // reference update
        n_cnt = m_cnt; n_rl = m_rl; n_rh = m_rh; n_ph = m_ph;
        if (r) begin
            for (int i = 0; i < 4; i++) begin n_cnt[i] = 0; n_rl[i] = 0; end
            n_rh = 0; n_ph = 0;
        end else begin
            wc = -1;
            if (one && c[1]) wc = 0;
            if (one && c[3]) wc = 1;
            if (one && c[6]) wc = 2;
            if (one && c[8]) wc = 3;
            if (one && c[4]) n_rl[1] = d;
            if (one && c[9]) n_rh = d;
            for (int i = 0; i < 4; i++) begin
                if (wc == i) begin
                    n_cnt[i] = d; n_rl[i] = d;
                    if (i == 3) n_ph = 0;
                end else if (i == 3 && one && c[10]) begin
                    n_cnt[3] = m_rl[3]; n_ph = 0;
                end else if (tk[i]) begin
                    if (m_cnt[i] != 0) n_cnt[i] = m_cnt[i] - 1;
                    else if (i == 3 && m_ph == 0) begin n_cnt[3] = m_rh; n_ph = 1; end
                    else begin n_cnt[i] = m_rl[i]; if (i == 3) n_ph = 0; end
                end
            end
        end
        m_cnt = n_cnt; m_rl = n_rl; m_rh = n_rh; m_ph = n_ph;
    endtask

    function automatic logic [10:0] bitv(input int b);
        return 11'(1) << b;
    endfunction

    initial begin
        rst = 1'b1; cmd = '0; lo_in = '0; hi_in = '0; tick = '0;
        for (int i = 0; i < 4; i++) begin m_cnt[i] = 0; m_rl[i] = 0; end
        m_rh = 0; m_ph = 0;
        repeat (3) @(posedge clk);
        // R1: reset state read back
        step(0, bitv(0), 8'h00, 4'h0, "R1");
        step(0, bitv(2), 8'h00, 4'h0, "R1");
        step(0, bitv(5), 8'h00, 4'h0, "R1");
        step(0, bitv(7), 8'h00, 4'h0, "R1");
        // R7: counters at zero with tick reload from zero and pulse uf
        step(0, '0, 8'h00, 4'hF, "R7");
        // R3, R2: writes and reads
        step(0, bitv(1), 8'hA5, 4'h0, "R3");
        step(0, bitv(0), 8'h00, 4'h0, "R2");
        step(0, bitv(3), 8'h03, 4'h0, "R3");
        step(0, bitv(6), 8'h3C, 4'h0, "R3");
        step(0, bitv(5), 8'h00, 4'h0, "R2");
        // R7: timer 1 counts down and reloads 3
        for (int k = 0; k < 6; k++) step(0, bitv(2), 8'h00, 4'h2, "R7");
        // R4: reload-only write leaves counter
        step(0, bitv(4), 8'h02, 4'h0, "R4");
        step(0, bitv(2), 8'h00, 4'h0, "R4");
        for (int k = 0; k < 8; k++) step(0, bitv(2), 8'h00, 4'h2, "R4");
        // R5, R8: timer 3 low 1, high 2
        step(0, bitv(8), 8'h01, 4'h0, "R3");
        step(0, bitv(9), 8'h02, 4'h0, "R5");
        step(0, bitv(7), 8'h00, 4'h0, "R5");
        for (int k = 0; k < 9; k++) step(0, bitv(7), 8'h00, 4'h8, "R8");
        // R6: copy low reload into counter, mid-phase
        step(0, '0, 8'h00, 4'h8, "R6");
        step(0, bitv(10), 8'h00, 4'h0, "R6");
        step(0, bitv(7), 8'h00, 4'h0, "R6");
        // R9: write during underflow and during tick
        step(0, bitv(6), 8'h00, 4'h0, "R9");
        step(0, bitv(6), 8'h44, 4'h4, "R9");
        step(0, bitv(5), 8'h00, 4'h0, "R9");
        step(0, bitv(10), 8'h00, 4'h8, "R9");
        step(0, bitv(7), 8'h00, 4'h0, "R9");
        // R10: multi-hot commands
        step(0, bitv(1) | bitv(3), 8'hEE, 4'h0, "R10");
        step(0, bitv(0) | bitv(2), 8'h00, 4'h0, "R10");
        step(0, bitv(0), 8'h00, 4'h0, "R10");
        step(0, bitv(2), 8'h00, 4'h0, "R10");
        // mixed traffic
        for (int k = 0; k < 600; k++) begin
            logic [10:0] c;
            int sel;
            sel = $urandom % 8;
            if (sel == 0)      c = 11'($urandom);
            else if (sel == 1) c = '0;
            else               c = bitv($urandom % 11);
            step(0, c, 8'($urandom % 6), 4'($urandom), "R7");
        end
        // R1: mid-run reset
        step(1, '0, 8'h00, 4'h0, "R1");
        step(0, bitv(7), 8'h00, 4'h0, "R1");
        step(0, bitv(0), 8'h00, 4'h0, "R1");
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule